// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This block is a memory-mapped watchdog. A logarithmic prescaler divides the input clock into ticks of 2^(BASE_LOG2 + prescale) cycles. One tick counter is shared by two phases that run back to back. The first phase ends with a pretimeout interrupt. The second phase ends with a one-cycle reset pulse on one of three reset outputs, chosen by a mode field.

Software configures the timer through a control register at offset 0x8. It keeps the timer alive by writing bit 31 of the offset 0x0 register; each such write restarts the count from the start of phase 1. Interrupts are acknowledged by writing ones to the status register at offset 0x4. Once phase 1 has expired, clearing the enable bit does not stop the timer, so a stalled system always reaches the reset.

The register port is a single-cycle write strobe with a combinational read. The base tick exponent BASE_LOG2 is a parameter (25 in silicon). A testbench can set it much smaller.

Top module: `wdt_two_phase`

## Requirements
- R1: After reset, control reads 0x00000001 (mode 1, everything else zero), status reads 0, and the interrupt and reset outputs are low.
- R2: Control fields are: bit 31 enable, bits 30:29 prescale, bits 26:22 phase-1 length, bits 19:15 phase-2 length, bits 1:0 reset mode. All other bits read back as 0. Offset 0x0 reads 0.
- R3: One tick lasts 2^(BASE_LOG2 + prescale) clock cycles, counted from the edge that enables the timer or pings it.
- R4: Phase 1 expires (P1+1) ticks after the enabling or ping edge. At that point status bit 31 sets and irq_pre goes high. Even P1 = 0 lasts one full tick.
- R5: Phase 2 starts at phase-1 expiry and lasts (P2+1) ticks. At its end, status bit 30 sets, irq_final goes high, and one reset output pulses for exactly one cycle.
- R6: Mode 0 pulses rst_soc, mode 1 pulses rst_cpu, mode 2 pulses rst_sw, and mode 3 acts as mode 0. At most one reset output is high at any time.
- R7: Writing 1 to status bit 31 or bit 30 clears that bit, and writing 0 leaves it unchanged. If an expiry happens in the same cycle as the clear, the set wins. irq_pre and irq_final follow status bits 31 and 30.
- R8: A write to offset 0x0 with bit 31 set clears the prescaler and the tick count and returns to phase 1. A write to offset 0x0 with bit 31 clear has no effect.
- R9: Clearing enable during phase 1 stops the timer and discards its progress. Clearing enable during phase 2 does not stop it, and the reset still occurs on time.
- R10: A ping received during phase 2 restarts the sequence from phase 1 but leaves status bit 31 set.
- R11: After the reset pulse the timer stays idle, producing no further pulses, until it is pinged or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_pre | output | 1 | Phase-1 expiry interrupt (level) |
| irq_final | output | 1 | Phase-2 expiry interrupt (level) |
| rst_soc | output | 1 | Full-chip reset pulse |
| rst_cpu | output | 1 | Processor-only reset pulse |
| rst_sw | output | 1 | Software reset pulse |

## Verification
The main sequence is run with random prescale, phase lengths and modes. Varying prescale separates the tick-length exponent from the phase counts, and varying P1 and P2 separately shows that both phases are timed and neither is merged into the other. Directed cases cover the following:
- pings in mid-phase and writes to offset 0x0 without bit 31, which separate a restart from an ignored write;
- disabling the timer in each phase, which separates the phase-1 stop from the phase-2 lock;
- a status clear written in the very cycle of expiry, which shows the set-wins ordering.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DATA_W  = 32;
    localparam int PHASE_W = 5;

    localparam int OFS_PING = 'h0;
    localparam int OFS_STAT = 'h4;
    localparam int OFS_CTRL = 'h8;

    localparam int EN_BIT  = 31;
    localparam int PS_LSB  = 29;
    localparam int P1_LSB  = 22;
    localparam int P2_LSB  = 15;
    localparam int ST1_BIT = 31;
    localparam int ST2_BIT = 30;
    localparam int PING_BIT = 31;

    typedef enum logic [1:0] {
        PH_ONE  = 2'd0,
        PH_TWO  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    typedef struct packed {
        logic               en;
        logic [1:0]         ps;
        logic [PHASE_W-1:0] p1;
        logic [PHASE_W-1:0] p2;
        logic [1:0]         mode;
    } ctrl_t;

    localparam logic [1:0] MODE_SOC = 2'd0;
    localparam logic [1:0] MODE_CPU = 2'd1;
    localparam logic [1:0] MODE_SW  = 2'd2;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int BASE_LOG2 = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       clr_i,
    input  logic [1:0] sel_i,
    output logic       tick_o
);
    localparam int CW = BASE_LOG2 + 4;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit  = (CW'(1) << (BASE_LOG2 + 32'(sel_i))) - CW'(1);
        tick_o = run_i && !clr_i && (cnt_q == limit);
        if (clr_i || !run_i || tick_o) cnt_d = '0;
        else                           cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wdt_phase_seq.sv
module wdt_phase_seq
    import wdt_pkg::*;
#(
    parameter int PW = PHASE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          ping_i,
    input  logic          tick_i,
    input  logic [PW-1:0] len1_i,
    input  logic [PW-1:0] len2_i,
    output logic          active_o,
    output logic          exp1_o,
    output logic          exp2_o
);
    typedef struct packed {
        phase_e        ph;
        logic [PW-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic [PW-1:0] cur_len;

    always_comb begin
        s_d      = s_q;
        exp1_o   = 1'b0;
        exp2_o   = 1'b0;
        active_o = (en_i && s_q.ph == PH_ONE) || (s_q.ph == PH_TWO);
        cur_len  = (s_q.ph == PH_TWO) ? len2_i : len1_i;
        if (ping_i) begin
            s_d.ph  = PH_ONE;
            s_d.cnt = '0;
        end else if (!active_o) begin
            if (s_q.ph == PH_ONE) s_d.cnt = '0;
        end else if (tick_i) begin
            if (s_q.cnt == cur_len) begin
                s_d.cnt = '0;
                if (s_q.ph == PH_ONE) begin
                    s_d.ph = PH_TWO;
                    exp1_o = 1'b1;
                end else begin
                    s_d.ph = PH_DONE;
                    exp2_o = 1'b1;
                end
            end else begin
                s_d.cnt = s_q.cnt + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_ONE, cnt: '0};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/wdt_rst_sel.sv
module wdt_rst_sel
    import wdt_pkg::*;
(
    input  logic       fire_i,
    input  logic [1:0] mode_i,
    output logic [2:0] sel_o
);
    // sel_o = {software, cpu, soc}
    always_comb begin
        sel_o = 3'b000;
        if (fire_i) begin
            unique case (mode_i)
                MODE_CPU: sel_o = 3'b010;
                MODE_SW:  sel_o = 3'b100;
                default:  sel_o = 3'b001;
            endcase
        end
    end
endmodule

// File: rtl/wdt_two_phase.sv
module wdt_two_phase
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 25,
    parameter int AW        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_pre,
    output logic              irq_final,
    output logic              rst_soc,
    output logic              rst_cpu,
    output logic              rst_sw
);
    typedef struct packed {
        ctrl_t      ctrl;
        logic       st1;
        logic       st2;
        logic [2:0] rst;
    } regs_t;

    regs_t r_d, r_q;
    logic  w_ping, w_stat, w_ctrl;
    logic  tick, active, exp1, exp2;
    logic [2:0] rst_next;
    logic [1:0] cur_mode;

    assign w_ping   = bus_we && bus_addr == AW'(OFS_PING) && bus_wdata[PING_BIT];
    assign w_stat   = bus_we && bus_addr == AW'(OFS_STAT);
    assign w_ctrl   = bus_we && bus_addr == AW'(OFS_CTRL);
    assign cur_mode = r_q.ctrl.mode;

    wdt_tick_gen #(.BASE_LOG2(BASE_LOG2)) u_tick (
        .clk(clk), .rst_n(rst_n), .run_i(active), .clr_i(w_ping),
        .sel_i(r_q.ctrl.ps), .tick_o(tick)
    );

    wdt_phase_seq #(.PW(PHASE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .en_i(r_q.ctrl.en), .ping_i(w_ping),
        .tick_i(tick), .len1_i(r_q.ctrl.p1), .len2_i(r_q.ctrl.p2),
        .active_o(active), .exp1_o(exp1), .exp2_o(exp2)
    );

    wdt_rst_sel u_sel (.fire_i(exp2), .mode_i(r_q.ctrl.mode), .sel_o(rst_next));

    always_comb begin
        r_d = r_q;
        if (w_ctrl) begin
            r_d.ctrl.en   = bus_wdata[EN_BIT];
            r_d.ctrl.ps   = bus_wdata[PS_LSB +: 2];
            r_d.ctrl.p1   = bus_wdata[P1_LSB +: PHASE_W];
            r_d.ctrl.p2   = bus_wdata[P2_LSB +: PHASE_W];
            r_d.ctrl.mode = bus_wdata[1:0];
        end
        r_d.st1 = exp1 || (r_q.st1 && !(w_stat && bus_wdata[ST1_BIT]));
        r_d.st2 = exp2 || (r_q.st2 && !(w_stat && bus_wdata[ST2_BIT]));
        r_d.rst = rst_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.ctrl.mode <= MODE_CPU;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFS_STAT)) begin
            bus_rdata[ST1_BIT] = r_q.st1;
            bus_rdata[ST2_BIT] = r_q.st2;
        end else if (bus_addr == AW'(OFS_CTRL)) begin
            bus_rdata[EN_BIT]               = r_q.ctrl.en;
            bus_rdata[PS_LSB +: 2]          = r_q.ctrl.ps;
            bus_rdata[P1_LSB +: PHASE_W]    = r_q.ctrl.p1;
            bus_rdata[P2_LSB +: PHASE_W]    = r_q.ctrl.p2;
            bus_rdata[1:0]                  = r_q.ctrl.mode;
        end
    end

    assign irq_pre   = r_q.st1;
    assign irq_final = r_q.st2;
    assign rst_soc   = r_q.rst[0];
    assign rst_cpu   = r_q.rst[1];
    assign rst_sw    = r_q.rst[2];
endmodule

// File: rtl/wdt_two_phase_chk.sv
module wdt_two_phase_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [31:0]   bus_wdata,
    input logic          irq_pre,
    input logic          irq_final,
    input logic          rst_soc,
    input logic          rst_cpu,
    input logic          rst_sw,
    input logic          exp1,
    input logic [1:0]    mode_q
);
    logic rst_any;
    assign rst_any = rst_soc || rst_cpu || rst_sw;

    p_onehot_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_soc, rst_cpu, rst_sw}));

    p_pulse_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_any |=> !rst_any);

    p_rst_has_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_any |-> irq_final);

    p_cpu_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cpu |-> $past(mode_q) == 2'd1);

    p_sw_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_sw |-> $past(mode_q) == 2'd2);

    p_soc_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_soc |-> ($past(mode_q) == 2'd0 || $past(mode_q) == 2'd3));

    p_w1c_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(4) && bus_wdata[31] && !exp1) |=> !irq_pre);
endmodule

bind wdt_two_phase wdt_two_phase_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq_pre(irq_pre), .irq_final(irq_final),
    .rst_soc(rst_soc), .rst_cpu(rst_cpu), .rst_sw(rst_sw),
    .exp1(exp1), .mode_q(cur_mode)
);

// File: tb/tb_wdt_two_phase.sv
`timescale 1ns/1ps
module tb_wdt_two_phase;
    localparam int BASE = 2;
    localparam int AW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_pre, irq_final, rst_soc, rst_cpu, rst_sw;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int t_last = 0;

    wdt_two_phase #(.BASE_LOG2(BASE), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pre(irq_pre),
        .irq_final(irq_final), .rst_soc(rst_soc), .rst_cpu(rst_cpu), .rst_sw(rst_sw)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mk(input bit en, input int ps, input int p1,
                                       input int p2, input int mode);
        logic [31:0] v = '0;
        v[31] = en; v[30:29] = 2'(ps); v[26:22] = 5'(p1); v[19:15] = 5'(p2); v[1:0] = 2'(mode);
        return v;
    endfunction
    function automatic int t1(input int ps, input int p1);
        return (p1 + 1) << (BASE + ps);
    endfunction
    function automatic int t2(input int ps, input int p1, input int p2);
        return (p1 + p2 + 2) << (BASE + ps);
    endfunction
    function automatic logic [2:0] exp_rst(input int mode);
        return (mode == 1) ? 3'b010 : (mode == 2) ? 3'b100 : 3'b001;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = AW'(addr); bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
        t_last = cyc;
    endtask

    task automatic rd(input int addr, output logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(addr);
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic wait_pre(input int lim, output int c);
        int n = 0;
        do begin @(posedge clk); #1; n++; end while (!irq_pre && n < lim);
        c = irq_pre ? cyc : -1;
    endtask

    task automatic wait_rst(input int lim, output int c, output logic [2:0] v);
        int n = 0;
        do begin @(posedge clk); #1; n++; end
        while (!(rst_soc || rst_cpu || rst_sw) && n < lim);
        v = {rst_sw, rst_cpu, rst_soc};
        c = (v != 0) ? cyc : -1;
    endtask

    task automatic prep(input int ps, input int p1, input int p2, input int mode);
        wr('h8, mk(0, ps, p1, p2, mode));
        wr('h0, 32'h8000_0000);
        wr('h4, 32'hC000_0000);
    endtask

    task automatic full_run(input int ps, input int p1, input int p2, input int mode);
        int c0, c1, c2;
        logic [2:0] v;
        logic [31:0] d;
        prep(ps, p1, p2, mode);
        wr('h8, mk(1, ps, p1, p2, mode));
        c0 = t_last;
        wait_pre(2000, c1);
        chk("R4/R3 phase-1 expiry cycle", c1, c0 + t1(ps, p1));
        wait_rst(2000, c2, v);
        chk("R5/R3 reset pulse cycle", c2, c0 + t2(ps, p1, p2));
        chk("R6 reset output select", 32'(v), 32'(exp_rst(mode)));
        idle(1);
        chk("R5 pulse width one cycle", 32'({rst_sw, rst_cpu, rst_soc}), 0);
        rd('h4, d);
        chk("R5 status after full run", d, 32'hC000_0000);
        chk("R7 irq lines follow status", 32'({irq_pre, irq_final}), 32'h3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int c0, c1, c2, c3;
        logic [2:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd('h8, d); chk("R1 control reset value", d, 32'h0000_0001);
        rd('h4, d); chk("R1 status reset value", d, 0);
        chk("R1 outputs low", 32'({irq_pre, irq_final, rst_soc, rst_cpu, rst_sw}), 0);

        // R2 field layout
        wr('h8, 32'h7FFF_FFFF);
        rd('h8, d); chk("R2 control field mask", d, 32'h67CF_8003);
        rd('h0, d); chk("R2 offset 0 reads zero", d, 0);
        idle(40);
        chk("R2 no run while disabled", 32'(irq_pre), 0);

        // Directed full runs, all modes, P1=0 boundary
        full_run(0, 0, 0, 0);
        full_run(0, 2, 1, 1);
        full_run(1, 1, 0, 2);
        full_run(0, 0, 3, 3);

        // R11 idle after reset pulse (enable still set)
        wait_rst(3 * t2(0, 0, 3) + 10, c2, v);
        chk("R11 no pulse after completion", 32'(c2), 32'hFFFF_FFFF);

        // Random runs
        for (int k = 0; k < 10; k++) begin
            full_run(int'($urandom_range(3)), int'($urandom_range(6)),
                     int'($urandom_range(6)), int'($urandom_range(3)));
        end

        // R8 ping mid phase 1
        prep(0, 3, 1, 2);
        wr('h8, mk(1, 0, 3, 1, 2));
        idle(7);
        wr('h0, 32'h8000_0000); c1 = t_last;
        wait_pre(200, c2);
        chk("R8 ping restarts phase 1", c2, c1 + 16);
        wait_rst(200, c3, v);
        chk("R8 reset after ping", c3, c1 + 24);

        // R8 write to offset 0 without bit 31 ignored
        prep(0, 3, 1, 2);
        wr('h8, mk(1, 0, 3, 1, 2)); c0 = t_last;
        idle(5);
        wr('h0, 32'h7FFF_FFFF);
        wait_pre(200, c1);
        chk("R8 non-ping write ignored", c1, c0 + 16);
        wait_rst(200, c3, v);

        // R9 disable in phase 1 discards progress
        prep(0, 3, 1, 2);
        wr('h8, mk(1, 0, 3, 1, 2));
        idle(6);
        wr('h8, mk(0, 0, 3, 1, 2));
        wait_pre(40, c1);
        chk("R9 disabled phase 1 stops", 32'(c1), 32'hFFFF_FFFF);
        wr('h8, mk(1, 0, 3, 1, 2)); c2 = t_last;
        wait_pre(200, c1);
        chk("R9 re-enable starts fresh", c1, c2 + 16);
        // R9 disable in phase 2 has no effect
        wr('h8, mk(0, 0, 3, 1, 2));
        wait_rst(200, c3, v);
        chk("R9 phase 2 locked, reset on time", c3, c2 + 24);
        chk("R9 mode in phase 2", 32'(v), 32'(exp_rst(2)));

        // R10 ping during phase 2 keeps status bit 31
        prep(0, 3, 1, 1);
        wr('h8, mk(1, 0, 3, 1, 1)); c0 = t_last;
        wait_pre(200, c1);
        idle(2);
        wr('h0, 32'h8000_0000); c3 = t_last;
        rd('h4, d);
        chk("R10 status bit 31 kept after ping", d, 32'h8000_0000);
        wait_rst(200, c2, v);
        chk("R10 sequence restarted by ping", c2, c3 + 24);

        // R7 write-one-to-clear and set-wins
        rd('h4, d); chk("R7 both flags set", d, 32'hC000_0000);
        wr('h4, 32'h4000_0000);
        rd('h4, d); chk("R7 clear bit 30 only", d, 32'h8000_0000);
        chk("R7 irq_final low after clear", 32'({irq_pre, irq_final}), 32'h2);
        wr('h4, 32'h0000_0000);
        rd('h4, d); chk("R7 writing zero no effect", d, 32'h8000_0000);
        wr('h4, 32'h8000_0000);
        rd('h4, d); chk("R7 clear bit 31", d, 0);
        prep(0, 1, 1, 0);
        wr('h8, mk(1, 0, 1, 1, 0)); c0 = t_last;
        while (cyc < c0 + t1(0, 1) - 1) begin @(posedge clk); #1; end
        wr('h4, 32'h8000_0000);
        chk("R7 clear write lands on expiry edge", t_last, c0 + t1(0, 1));
        rd('h4, d); chk("R7 set wins over clear", d, 32'h8000_0000);
        wait_rst(200, c3, v);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule